// File: doc/BRIEF.md
# Selectable Attribute and Planar Pixel Decoder

This block sits in a 256x192 display pipeline between the memory fetch and the palette lookup. For each group of eight pixels it receives one pixel byte with its attribute byte, or four bitplane bytes. It turns the group into eight 8-bit logical colour indices and sends them out one per clock cycle, starting with the most significant pixel bit.

The attribute interpretation is chosen at run time through a control port. Each write to I/O address 0x8E3B carries a register number in its upper nibble and a value in its lower nibble. Register 3 holds the decode method. Five methods are available:

- the classic ink/paper/bright/flash format;
- a 16+16 format with a separate bright bit for ink and for paper;
- a 32-colour format with four brightness levels;
- a 256-colour ink mode whose paper is the border colour;
- a four-plane planar mode that ignores the attribute byte.

The decode method, the border colour and the flash phase are all sampled when a group is loaded. A change to any of them therefore never splits a group of eight pixels.

Top module: `pixel_decode`

## Requirements
- R1: While reset is asserted, pix_valid is 0 and colour is 0. After reset the decode method is classic (value 0000).
- R2: A control write updates the decode method only when io_addr is 0x8E3B and io_data[7:4] is 3. In that case io_data[3:0] becomes the method. A write to any other address, or to any other register number, leaves the method unchanged.
- R3: Classic method (0000) uses ink = attr[2:0], paper = attr[5:3], bright = attr[6] and flash = attr[7]. A set pixel gives {4'b0, bright, ink} and a clear pixel gives {4'b0, bright, paper}.
- R4: In the classic method, when attr[7] is 1 and the flash phase sampled at load is 1, ink and paper swap roles. When either of them is 0, there is no swap.
- R5: The 16+16 method (0001) outputs {4'b0, attr[6], ink} for a set pixel and {4'b0, attr[7], paper} for a clear pixel.
- R6: The 32-colour method (0010) outputs {3'b0, attr[7:6], c}. Here c is ink for a set pixel and paper for a clear pixel.
- R7: The 256-colour method (0100) outputs attr[7:0] for a set pixel and {5'b0, border} for a clear pixel.
- R8: The planar method (0110) outputs {4'b0, p3, p2, p1, p0}. Here pn is the bit of plane n (plane_bytes[8n+7:8n]) at the current pixel position. The pixel and attribute bytes have no effect.
- R9: Any decode method value other than 0000, 0001, 0010, 0100 and 0110 decodes exactly as the classic method.
- R10: A load pulse starts a group. pix_valid is 1 for the eight cycles after the load edge, and pixel bit 7 comes first and bit 0 last. At other times pix_valid is 0 and colour is 0. The method, border and flash phase in force at the load edge apply to the whole group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_data | input | 8 | I/O write data: register number in bits 7:4, value in bits 3:0 |
| load | input | 1 | Latch a new group of eight pixels |
| pix_byte | input | 8 | Pixel bitmap byte |
| attr_byte | input | 8 | Attribute byte |
| plane_bytes | input | 32 | Four plane bytes, plane n in bits 8n+7:8n |
| border | input | 3 | Border colour |
| flash_phase | input | 1 | Flash phase |
| colour | output | 8 | Logical colour of the current pixel |
| pix_valid | output | 1 | colour carries a pixel |

## Verification
A corrupted decode-method register shows up at the colour output on the first pixel of the next loaded group. For most attribute bytes the error then persists for the whole group, because the field extraction differs between methods. A wrong shift or count state shows up within one cycle as a misplaced pixel bit or a pix_valid pulse of the wrong length. A wrong sampled flash phase or border appears only on pixels that select paper or that have flash set, so the stimulus mixes set and clear bits in every pixel byte.

// File: rtl/pixel_decode.sv
module pixel_decode #(
  parameter logic [15:0] CTRL_PORT = 16'h8E3B,
  parameter logic [3:0]  MODE_REG  = 4'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_data,
  input  logic        load,
  input  logic [7:0]  pix_byte,
  input  logic [7:0]  attr_byte,
  input  logic [31:0] plane_bytes,
  input  logic [2:0]  border,
  input  logic        flash_phase,
  output logic [7:0]  colour,
  output logic        pix_valid
);
  localparam logic [3:0] M_CLASSIC = 4'b0000;
  localparam logic [3:0] M_DUAL    = 4'b0001;
  localparam logic [3:0] M_LEVEL4  = 4'b0010;
  localparam logic [3:0] M_INK256  = 4'b0100;
  localparam logic [3:0] M_PLANAR  = 4'b0110;

  logic [3:0]      mode_q, cur_mode;
  logic [7:0]      sh_pix, attr_q;
  logic [3:0][7:0] sh_pl;
  logic [2:0]      border_q;
  logic            flash_q;
  logic [3:0]      cnt;
  logic [7:0]      dec;

  wire ctrl_hit = io_wr && io_addr == CTRL_PORT && io_data[7:4] == MODE_REG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_CLASSIC;
      cur_mode <= M_CLASSIC;
      sh_pix   <= '0;
      sh_pl    <= '0;
      attr_q   <= '0;
      border_q <= '0;
      flash_q  <= 1'b0;
      cnt      <= '0;
    end else begin
      if (ctrl_hit) mode_q <= io_data[3:0];
      if (load) begin
        cur_mode <= mode_q;
        sh_pix   <= pix_byte;
        sh_pl    <= plane_bytes;
        attr_q   <= attr_byte;
        border_q <= border;
        flash_q  <= flash_phase;
        cnt      <= 4'd8;
      end else if (cnt != 0) begin
        sh_pix <= sh_pix << 1;
        for (int p = 0; p < 4; p++) sh_pl[p] <= sh_pl[p] << 1;
        cnt <= cnt - 4'd1;
      end
    end
  end

  wire [2:0] ink   = attr_q[2:0];
  wire [2:0] paper = attr_q[5:3];
  wire       on    = sh_pix[7];

  always_comb begin
    unique case (cur_mode)
      M_DUAL:   dec = on ? {4'b0, attr_q[6], ink} : {4'b0, attr_q[7], paper};
      M_LEVEL4: dec = {3'b0, attr_q[7:6], on ? ink : paper};
      M_INK256: dec = on ? attr_q : {5'b0, border_q};
      M_PLANAR: dec = {4'b0, sh_pl[3][7], sh_pl[2][7], sh_pl[1][7], sh_pl[0][7]};
      default:  dec = {4'b0, attr_q[6], (on ^ (attr_q[7] & flash_q)) ? ink : paper};
    endcase
  end

  assign pix_valid = cnt != 0;
  assign colour    = pix_valid ? dec : 8'h00;
endmodule

// File: rtl/pixel_decode_chk.sv
module pixel_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [7:0]  io_data,
  input logic        load,
  input logic        pix_valid,
  input logic [7:0]  colour,
  input logic [3:0]  mode_q,
  input logic [3:0]  cur_mode
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!pix_valid && mode_q == 4'b0000));

  assert_foreign_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr != 16'h8E3B || io_data[7:4] != 4'd3)) |=> $stable(mode_q));

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h8E3B && io_data[7:4] == 4'd3) |=> mode_q == $past(io_data[3:0]));

  assert_classic_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (cur_mode == 4'b0000 || cur_mode == 4'b0001)) |-> colour[7:4] == 4'h0);

  assert_level4_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && cur_mode == 4'b0010) |-> colour[7:5] == 3'b0);

  assert_planar_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && cur_mode == 4'b0110) |-> colour[7:4] == 4'h0);

  assert_group_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pix_valid);

  assert_idle_black_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> colour == 8'h00);
endmodule

bind pixel_decode pixel_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
  .load(load), .pix_valid(pix_valid), .colour(colour), .mode_q(mode_q), .cur_mode(cur_mode)
);

// File: tb/pixel_decode_tb.sv
module pixel_decode_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic        load = 0;
  logic [7:0]  pix_byte = '0, attr_byte = '0;
  logic [31:0] plane_bytes = '0;
  logic [2:0]  border = '0;
  logic        flash_phase = 0;
  logic [7:0]  colour;
  logic        pix_valid;

  int checks = 0, fails = 0;
  logic [3:0] tb_mode = 4'b0000;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_decode u_dut (.*);

  function automatic logic [7:0] model(logic [3:0] m, logic [7:0] px, logic [7:0] at,
                                       logic [31:0] pl, logic [2:0] bd, logic fl, int i);
    logic s = px[i];
    case (m)
      4'b0001: return s ? {4'b0, at[6], at[2:0]} : {4'b0, at[7], at[5:3]};
      4'b0010: return {3'b0, at[7:6], s ? at[2:0] : at[5:3]};
      4'b0100: return s ? at : {5'b0, bd};
      4'b0110: return {4'b0, pl[24+i], pl[16+i], pl[8+i], pl[i]};
      default: begin
        if (at[7] && fl) s = !s;
        return {4'b0, at[6], s ? at[2:0] : at[5:3]};
      end
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_addr = a; io_data = d;
    if (a == 16'h8E3B && d[7:4] == 4'd3) tb_mode = d[3:0];
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic send(string tag, logic [7:0] px, logic [7:0] at, logic [31:0] pl,
                      logic [2:0] bd, logic fl, logic mid_wr = 0, logic [7:0] mid_d = 0);
    @(negedge clk);
    load = 1; pix_byte = px; attr_byte = at; plane_bytes = pl; border = bd; flash_phase = fl;
    for (int i = 7; i >= 0; i--) begin
      exp_q.push_back(model(tb_mode, px, at, pl, bd, fl, i));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    load = 0; border = ~bd; flash_phase = ~fl; pix_byte = ~px; attr_byte = ~at;
    plane_bytes = ~pl;
    if (mid_wr) begin
      io_wr = 1; io_addr = 16'h8E3B; io_data = mid_d;
      @(negedge clk);
      io_wr = 0;
      tb_mode = mid_d[3:0];
      repeat (6) @(negedge clk);
    end else repeat (7) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected pixel", colour, 8'hxx);
      else check(tag_q.pop_front(), colour, exp_q.pop_front());
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {7'b0, pix_valid}, 8'h00);
    check("R1 colour in reset", colour, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", {7'b0, pix_valid}, 8'h00);
    send("R1 default classic", 8'hA5, 8'h53, 32'h0, 3'd1, 1'b0);

    wr(16'h8E3B, 8'h30);
    send("R3 classic flash bit, phase 0", 8'hC3, 8'hD3, 32'h0, 3'd2, 1'b0);
    send("R3 classic no bright", 8'h96, 8'h2C, 32'h0, 3'd2, 1'b0);
    send("R4 flash swap", 8'hC3, 8'hD3, 32'h0, 3'd2, 1'b1);
    send("R4 no flash bit, phase 1", 8'h3C, 8'h53, 32'h0, 3'd2, 1'b1);

    wr(16'h8E3B, 8'h31);
    send("R5 16+16 paper bright", 8'hA9, 8'h9A, 32'h0, 3'd3, 1'b1);
    send("R5 16+16 ink bright", 8'h5E, 8'h5A, 32'h0, 3'd3, 1'b0);

    wr(16'h8E3B, 8'h32);
    send("R6 32-colour level 3", 8'hE1, 8'hC5, 32'h0, 3'd4, 1'b1);
    send("R6 32-colour level 1", 8'h1E, 8'h45, 32'h0, 3'd4, 1'b0);
    send("R6 32-colour level 2", 8'h81, 8'hBE, 32'h0, 3'd4, 1'b0);

    wr(16'h8E3B, 8'h34);
    send("R7 256 ink, border paper", 8'hB4, 8'hE7, 32'h0, 3'd5, 1'b1);
    send("R7 256 ink other border", 8'h4B, 8'h12, 32'h0, 3'd6, 1'b0);

    wr(16'h8E3B, 8'h36);
    send("R8 planar", 8'hFF, 8'h00, 32'hF0CC_AA0F, 3'd7, 1'b1);
    send("R8 planar ignores attr/pixel", 8'h00, 8'hFF, 32'h3C96_5A81, 3'd0, 1'b0);

    wr(16'h7FFD, 8'h30);
    send("R2 other address ignored", 8'h0F, 8'h47, 32'h1234_5678, 3'd1, 1'b0);
    wr(16'h8E3B, 8'h50);
    send("R2 other register ignored", 8'hF0, 8'h47, 32'h8765_4321, 3'd1, 1'b0);

    wr(16'h8E3B, 8'h35);
    send("R9 value 0101 as classic", 8'hC3, 8'hD3, 32'h0, 3'd2, 1'b1);
    wr(16'h8E3B, 8'h3F);
    send("R9 value 1111 as classic", 8'h69, 8'h8E, 32'h0, 3'd2, 1'b1);

    wr(16'h8E3B, 8'h30);
    send("R10 mode change mid-group", 8'hA7, 8'hD9, 32'h0, 3'd3, 1'b1, 1'b1, 8'h34);
    send("R10 new mode on next group", 8'hA7, 8'hD9, 32'h0, 3'd3, 1'b0);

    repeat (3) @(negedge clk);
    check("R10 valid idle after group", {7'b0, pix_valid}, 8'h00);
    check("R10 colour idle after group", colour, 8'h00);
    check("R10 all expected pixels seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule